// File: doc/BRIEF.md
# Message-Authentication Coprocessor Register Front End

This block is the bus-facing register file of a one-time-authenticator coprocessor built on the 2^130-5 prime-field polynomial hash. A processor talks to it over a plain 32-bit request/response bus. It writes the 128-bit multiplier key, the 128-bit final addend key and one 128-bit message block as four words each, least-significant word first. Through a control word it marks the block as full and/or first and raises a load request. It then polls a status word until the arithmetic core reports that the block is done, clears the status, and after the last block reads the 128-bit tag as four words.

The block decodes word addresses and applies byte enables lane by lane. It answers every request one cycle later and drives the read data in that response cycle. It turns the rising edge of the load bit into a single start pulse for the core and latches the core's one-cycle ready pulse into the status word. When that pulse meets a software write to the status word in the same cycle, the hardware value wins. The arithmetic core sits outside the block. The block drives the key, message and control levels to it and shows the core's tag output as read-only words.

Top module: `mac_coproc_regs`

## Requirements
- R1: After a synchronous active-low reset, all key, message and control registers are zero. The status bit is 0, rvalid and the start pulse are low, and read data is zero.
- R2: Multiplier-key words sit at byte offsets 0, 4, 8, 12, addend-key words at 16 to 28, and message words at 32 to 44, least-significant word first. Each group drives its 128-bit core output, with the word at the lowest offset in bits 31:0.
- R3: On a write, byte-enable bit i updates only bits 8i+7:8i of the addressed word, and bytes whose enable is 0 keep their value.
- R4: rvalid is high exactly in the cycle after each request, whether read or write. In that cycle a read of a mapped word returns its data; in every other case read data is zero.
- R5: Offsets 48, 52, 56, 60 read the core tag input words, least-significant first. Writes to them change nothing.
- R6: The control word sits at offset 64. Bit 0 means full block, bit 1 means load request, bit 2 means first block. The three bits read back in place with zero above them, and bits 0 and 2 drive the full and first outputs. A control write needs byte-enable bit 0.
- R7: A rising edge of the load bit gives exactly one start pulse, in the cycle after the write. Writing load as 1 while it is already 1 gives no pulse.
- R8: The status word sits at offset 68 and reads 1 in bit 0 from the cycle after a core ready pulse. It stays 1 until software writes bit 0 as 0 with byte-enable bit 0 set.
- R9: A core ready pulse in the same cycle as a software write that clears status leaves status at 1.
- R10: Addresses that are not a multiple of 4, or are 72 or above, read as zero, and writes to them change no register and raise no start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Synchronous reset, active low |
| bus_req_i | input | 1 | Request valid for one cycle |
| bus_addr_i | input | AW | Byte address relative to the block |
| bus_we_i | input | 1 | 1 = write, 0 = read |
| bus_be_i | input | 4 | Byte enables for the write lanes |
| bus_wdata_i | input | 32 | Write data |
| bus_rvalid_o | output | 1 | Response valid, one cycle after request |
| bus_rdata_o | output | 32 | Read data during the response cycle |
| core_key_r_o | output | 128 | Multiplier key to the core |
| core_key_s_o | output | 128 | Final addend key to the core |
| core_msg_o | output | 128 | Message block to the core |
| core_full_o | output | 1 | Block holds 16 full bytes |
| core_first_o | output | 1 | Block is the first of a message |
| core_start_o | output | 1 | One-cycle start of one block |
| core_ready_i | input | 1 | One-cycle block-done pulse from the core |
| core_tag_i | input | 128 | Tag value from the core |

## Verification
On every cycle, the embedded properties check the response timing and the zero data returned for unmapped reads. They also check per-lane loading and holding under byte enables, the single-cycle start pulse, and that status is set by ready even against a competing software clear. Some behaviours only the bench scenarios can show: the full address map seen from the bus, that writes to tag and unmapped addresses leave every register unchanged, that a repeated load write does not start a second block, and the tag readback after a modelled core finishes.

// File: rtl/mac_coproc_pkg.sv
// Shared constants and types of the coprocessor register front end.
// Assumes a 32-bit data bus and the fixed word-slot layout below.
package mac_coproc_pkg;
    localparam int WORD_W    = 32;
    localparam int LANES     = WORD_W / 8;
    localparam int BLK_WORDS = 4;
    localparam int BLK_W     = BLK_WORDS * WORD_W;
    localparam int RW_WORDS  = 3 * BLK_WORDS;
    localparam int SLOT_W    = 5;
    localparam int SLOT_R    = 0;
    localparam int SLOT_S    = SLOT_R + BLK_WORDS;
    localparam int SLOT_M    = SLOT_S + BLK_WORDS;
    localparam int SLOT_TAG  = SLOT_M + BLK_WORDS;
    localparam int SLOT_CTL  = SLOT_TAG + BLK_WORDS;
    localparam int SLOT_STAT = SLOT_CTL + 1;
    localparam int NUM_SLOTS = SLOT_STAT + 1;
    localparam int CTL_W     = 3;
    localparam int CTL_FULL  = 0;
    localparam int CTL_LOAD  = 1;
    localparam int CTL_FIRST = 2;

    typedef logic [SLOT_W-1:0] slot_t;

    typedef struct packed {
        logic  hit;
        logic  wr;
        logic  rd;
        slot_t slot;
    } bus_dec_t;
endpackage

// File: rtl/mac_addr_decode.sv
// Address decoder: maps a byte address to a word slot.
// Assumes AW >= 7. Misaligned or out-of-map addresses produce no hit (R10).
module mac_addr_decode
    import mac_coproc_pkg::*;
#(
    parameter int AW = 8
) (
    input  logic          req_i,
    input  logic          we_i,
    input  logic [AW-1:0] addr_i,
    output bus_dec_t      dec_o
);
    localparam int UW = AW - 2;
    localparam logic [UW-1:0] LIMIT = UW'(NUM_SLOTS);

    logic [UW-1:0] upper;
    logic          aligned;
    logic          in_map;

    assign upper   = addr_i[AW-1:2];
    assign aligned = (addr_i[1:0] == 2'b00);
    assign in_map  = aligned && (upper < LIMIT);

    // Build the decoded request for this cycle.
    always_comb begin
        dec_o.hit  = in_map;
        dec_o.wr   = req_i & we_i & in_map;
        dec_o.rd   = req_i & ~we_i & in_map;
        dec_o.slot = in_map ? upper[SLOT_W-1:0] : '0;
    end
endmodule

// File: rtl/mac_lane_reg.sv
// Software-writable word register with independent byte lanes (R3).
// Assumes W is a multiple of 8; reset clears every lane (R1).
module mac_lane_reg #(
    parameter int W = 32
) (
    input  logic           clk_i,
    input  logic           rst_ni,
    input  logic           wr_en_i,
    input  logic [W/8-1:0] be_i,
    input  logic [W-1:0]   wdata_i,
    output logic [W-1:0]   q_o
);
    localparam int NL = W / 8;

    logic [W-1:0] q;

    for (genvar b = 0; b < NL; b++) begin : g_lane
        // Load one byte lane when its enable is set.
        always_ff @(posedge clk_i) begin
            if (!rst_ni)
                q[8*b +: 8] <= '0;
            else if (wr_en_i && be_i[b])
                q[8*b +: 8] <= wdata_i[8*b +: 8];
        end

        p_lane_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
            !(wr_en_i && be_i[b]) |=> $stable(q[8*b +: 8]));

        p_lane_load_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (wr_en_i && be_i[b]) |=> (q[8*b +: 8] == $past(wdata_i[8*b +: 8])));
    end

    assign q_o = q;
endmodule

// File: rtl/mac_ctl_stat.sv
// Control word, load-edge start pulse and done status latch.
// Assumes the core ready input is a one-cycle pulse; hardware set wins (R9).
module mac_ctl_stat
    import mac_coproc_pkg::*;
(
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             ctl_wr_i,
    input  logic             stat_wr_i,
    input  logic             be0_i,
    input  logic [CTL_W-1:0] wdata_i,
    input  logic             core_ready_i,
    output logic [CTL_W-1:0] ctl_o,
    output logic             done_o,
    output logic             start_o
);
    logic [CTL_W-1:0] ctl_q;
    logic             load_seen_q;
    logic             done_q;

    // Control register, written only by software through lane 0 (R6).
    always_ff @(posedge clk_i) begin
        if (!rst_ni)
            ctl_q <= '0;
        else if (ctl_wr_i && be0_i)
            ctl_q <= wdata_i;
    end

    // Previous load level, for rising-edge start detection (R7).
    always_ff @(posedge clk_i) begin
        if (!rst_ni)
            load_seen_q <= 1'b0;
        else
            load_seen_q <= ctl_q[CTL_LOAD];
    end

    // Done latch: core ready sets it ahead of any software write (R8, R9).
    always_ff @(posedge clk_i) begin
        if (!rst_ni)
            done_q <= 1'b0;
        else if (core_ready_i)
            done_q <= 1'b1;
        else if (stat_wr_i && be0_i)
            done_q <= wdata_i[0];
    end

    assign start_o = ctl_q[CTL_LOAD] & ~load_seen_q;
    assign ctl_o   = ctl_q;
    assign done_o  = done_q;

    p_start_single_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        start_o |=> !start_o);

    p_ready_sets_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        core_ready_i |=> done_q);

    p_clear_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (stat_wr_i && be0_i && !wdata_i[0] && !core_ready_i) |=> !done_q);
endmodule

// File: rtl/mac_read_mux.sv
// Response path: rvalid one cycle after each request and read data chosen
// by a registered copy of the read decode (R4). Assumes slots below the
// control slot form one contiguous word view.
module mac_read_mux
    import mac_coproc_pkg::*;
(
    input  logic                           clk_i,
    input  logic                           rst_ni,
    input  logic                           req_i,
    input  bus_dec_t                       dec_i,
    input  logic [SLOT_CTL-1:0][WORD_W-1:0] view_i,
    input  logic [CTL_W-1:0]               ctl_i,
    input  logic                           done_i,
    output logic                           rvalid_o,
    output logic [WORD_W-1:0]              rdata_o
);
    localparam int VIEW_IW = $clog2(SLOT_CTL);

    logic  rvalid_q;
    logic  rd_hit_q;
    slot_t rd_slot_q;

    // Register the response flag and the read selection.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            rvalid_q  <= 1'b0;
            rd_hit_q  <= 1'b0;
            rd_slot_q <= '0;
        end else begin
            rvalid_q  <= req_i;
            rd_hit_q  <= dec_i.rd;
            rd_slot_q <= dec_i.slot;
        end
    end

    // Select the read word in the response cycle; zero otherwise.
    always_comb begin
        rdata_o = '0;
        if (rd_hit_q) begin
            if (rd_slot_q < SLOT_W'(SLOT_CTL))
                rdata_o = view_i[rd_slot_q[VIEW_IW-1:0]];
            else if (rd_slot_q == SLOT_W'(SLOT_CTL))
                rdata_o = {{(WORD_W-CTL_W){1'b0}}, ctl_i};
            else
                rdata_o = {{(WORD_W-1){1'b0}}, done_i};
        end
    end

    assign rvalid_o = rvalid_q;

    p_rvalid_on_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        req_i |=> rvalid_o);

    p_rvalid_off_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !req_i |=> !rvalid_o);
endmodule

// File: rtl/mac_coproc_regs.sv
// Top of the register front end: decoder, twelve key/message words,
// control/status unit and response mux. Assumes a single outstanding
// request per cycle and a core that pulses ready once per start.
module mac_coproc_regs
    import mac_coproc_pkg::*;
#(
    parameter int AW = 8
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              bus_req_i,
    input  logic [AW-1:0]     bus_addr_i,
    input  logic              bus_we_i,
    input  logic [LANES-1:0]  bus_be_i,
    input  logic [WORD_W-1:0] bus_wdata_i,
    output logic              bus_rvalid_o,
    output logic [WORD_W-1:0] bus_rdata_o,
    output logic [BLK_W-1:0]  core_key_r_o,
    output logic [BLK_W-1:0]  core_key_s_o,
    output logic [BLK_W-1:0]  core_msg_o,
    output logic              core_full_o,
    output logic              core_first_o,
    output logic              core_start_o,
    input  logic              core_ready_i,
    input  logic [BLK_W-1:0]  core_tag_i
);
    bus_dec_t                            dec;
    logic [RW_WORDS-1:0][WORD_W-1:0]     words_q;
    logic [BLK_WORDS-1:0][WORD_W-1:0]    tag_w;
    logic [SLOT_CTL-1:0][WORD_W-1:0]     view;
    logic [CTL_W-1:0]                    ctl;
    logic                                done;

    mac_addr_decode #(.AW(AW)) u_dec (
        .req_i  (bus_req_i),
        .we_i   (bus_we_i),
        .addr_i (bus_addr_i),
        .dec_o  (dec)
    );

    // Key and message words; tag slots have no storage (R2, R5).
    for (genvar i = 0; i < RW_WORDS; i++) begin : g_word
        mac_lane_reg #(.W(WORD_W)) u_word (
            .clk_i   (clk_i),
            .rst_ni  (rst_ni),
            .wr_en_i (dec.wr && (dec.slot == SLOT_W'(i))),
            .be_i    (bus_be_i),
            .wdata_i (bus_wdata_i),
            .q_o     (words_q[i])
        );
    end

    mac_ctl_stat u_ctl (
        .clk_i        (clk_i),
        .rst_ni       (rst_ni),
        .ctl_wr_i     (dec.wr && (dec.slot == SLOT_W'(SLOT_CTL))),
        .stat_wr_i    (dec.wr && (dec.slot == SLOT_W'(SLOT_STAT))),
        .be0_i        (bus_be_i[0]),
        .wdata_i      (bus_wdata_i[CTL_W-1:0]),
        .core_ready_i (core_ready_i),
        .ctl_o        (ctl),
        .done_o       (done),
        .start_o      (core_start_o)
    );

    assign tag_w = core_tag_i;
    assign view  = {tag_w, words_q};

    mac_read_mux u_rd (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .req_i    (bus_req_i),
        .dec_i    (dec),
        .view_i   (view),
        .ctl_i    (ctl),
        .done_i   (done),
        .rvalid_o (bus_rvalid_o),
        .rdata_o  (bus_rdata_o)
    );

    // Core-facing key, message and block-flag levels (R2, R6).
    assign core_key_r_o = words_q[SLOT_R +: BLK_WORDS];
    assign core_key_s_o = words_q[SLOT_S +: BLK_WORDS];
    assign core_msg_o   = words_q[SLOT_M +: BLK_WORDS];
    assign core_full_o  = ctl[CTL_FULL];
    assign core_first_o = ctl[CTL_FIRST];

    p_unmapped_zero_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (bus_req_i && !bus_we_i && !dec.hit) |=> (bus_rdata_o == '0));

    p_write_resp_zero_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (bus_req_i && bus_we_i) |=> (bus_rdata_o == '0));
endmodule

// File: tb/mac_coproc_regs_tb_top.sv
// Self-checking bench: address and byte-enable sweeps, block sequencing
// with a fixed-latency core model, and the status conflict case.
module mac_coproc_regs_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int AW         = 8;
    localparam int CORE_LAT   = 5;
    localparam int WD_LIMIT   = 100000;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         req = 1'b0;
    logic [AW-1:0] addr = '0;
    logic         we = 1'b0;
    logic [3:0]   be = '0;
    logic [31:0]  wdata = '0;
    logic         rvalid;
    logic [31:0]  rdata;
    logic [127:0] key_r, key_s, msg, tag_q;
    logic         full, first, start;
    logic         stub_ready, man_ready;
    int           busy_cnt;
    int           start_cnt = 0;
    int           cyc = 0;
    int           checks = 0;
    int           errors = 0;
    logic [31:0]  mdl [12];

    always #(CLK_PERIOD/2) clk = ~clk;

    mac_coproc_regs #(.AW(AW)) dut_i (
        .clk_i (clk), .rst_ni (rst_n),
        .bus_req_i (req), .bus_addr_i (addr), .bus_we_i (we),
        .bus_be_i (be), .bus_wdata_i (wdata),
        .bus_rvalid_o (rvalid), .bus_rdata_o (rdata),
        .core_key_r_o (key_r), .core_key_s_o (key_s), .core_msg_o (msg),
        .core_full_o (full), .core_first_o (first), .core_start_o (start),
        .core_ready_i (stub_ready | man_ready), .core_tag_i (tag_q)
    );

    // Core model: fixed latency, tag = message + addend key.
    always @(posedge clk) begin
        if (!rst_n) begin
            busy_cnt   <= 0;
            stub_ready <= 1'b0;
            tag_q      <= '0;
        end else if (start) begin
            busy_cnt   <= CORE_LAT;
            stub_ready <= 1'b0;
        end else begin
            stub_ready <= (busy_cnt == 1);
            if (busy_cnt == 1) tag_q <= msg + key_s;
            if (busy_cnt != 0) busy_cnt <= busy_cnt - 1;
        end
    end

    always @(posedge clk) if (start) start_cnt <= start_cnt + 1;

    // Watchdog: a hung run counts as one failed check.
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc == WD_LIMIT) begin
            errors = errors + 1;
            $display("FAIL watchdog all-reqs actual %0d cycles expected fewer", cyc);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
        checks = checks + 1;
        if (act !== exp) begin
            errors = errors + 1;
            $display("FAIL %s actual %h expected %h", rq, act, exp);
        end
    endtask

    // Call at a negedge; returns at the negedge of the response cycle.
    task automatic bus_write(input logic [AW-1:0] a, input logic [31:0] d, input logic [3:0] b);
        req = 1'b1; addr = a; we = 1'b1; wdata = d; be = b;
        @(negedge clk);
        req = 1'b0; we = 1'b0;
        chk("R4 write rvalid", {31'b0, rvalid}, 32'd1);
        chk("R4 write rdata zero", rdata, 32'd0);
    endtask

    task automatic bus_read(input logic [AW-1:0] a, output logic [31:0] d);
        req = 1'b1; addr = a; we = 1'b0;
        @(negedge clk);
        req = 1'b0;
        chk("R4 read rvalid", {31'b0, rvalid}, 32'd1);
        d = rdata;
    endtask

    function automatic logic [31:0] merge(input logic [31:0] o, input logic [31:0] n, input logic [3:0] b);
        logic [31:0] r = o;
        for (int k = 0; k < 4; k++) if (b[k]) r[8*k +: 8] = n[8*k +: 8];
        return r;
    endfunction

    task automatic check_core_words(input string rq);
        for (int k = 0; k < 4; k++) begin
            chk(rq, key_r[32*k +: 32], mdl[k]);
            chk(rq, key_s[32*k +: 32], mdl[4+k]);
            chk(rq, msg[32*k +: 32], mdl[8+k]);
        end
    endtask

    initial begin
        logic [31:0] d;
        logic [127:0] exp_tag;
        int s0;
        man_ready = 1'b0;
        for (int k = 0; k < 12; k++) mdl[k] = '0;
        repeat (3) @(negedge clk);
        // R1: reset state.
        chk("R1 rvalid", {31'b0, rvalid}, 32'd0);
        chk("R1 rdata", rdata, 32'd0);
        chk("R1 start", {31'b0, start}, 32'd0);
        chk("R1 flags", {30'b0, full, first}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check_core_words("R1 key/msg zero");

        // R2/R10: read sweep over every address.
        for (int a = 0; a < 256; a++) begin
            bus_read(AW'(a), d);
            chk((a % 4 != 0 || a >= 72) ? "R10 unmapped read" : "R2 mapped read", d, 32'd0);
        end

        // R10/R5: junk writes to unmapped and tag addresses change nothing.
        s0 = start_cnt;
        for (int a = 0; a < 256; a++)
            if (a % 4 != 0 || a >= 48 && a < 64 || a >= 72)
                bus_write(AW'(a), 32'hFFFF_FFFF, 4'hF);
        @(negedge clk);
        check_core_words("R10 words unchanged");
        chk("R10 no start", start_cnt, s0);
        bus_read(8'd64, d); chk("R10 ctl unchanged", d, 32'd0);
        bus_read(8'd68, d); chk("R10 stat unchanged", d, 32'd0);
        for (int k = 0; k < 4; k++) begin
            bus_read(AW'(48 + 4*k), d); chk("R5 tag write ignored", d, 32'd0);
        end

        // R3/R2: every byte-enable pattern on every writable word.
        for (int w = 0; w < 12; w++) begin
            for (int b = 0; b < 16; b++) begin
                logic [31:0] pat = 32'h9E37_79B9 * (w * 16 + b + 1);
                bus_write(AW'(4*w), pat, 4'(b));
                mdl[w] = merge(mdl[w], pat, 4'(b));
                bus_read(AW'(4*w), d);
                chk("R3 byte lanes", d, mdl[w]);
            end
        end
        check_core_words("R2 core word order");

        // R6/R7/R8: start one first full block and poll.
        s0 = start_cnt;
        bus_write(8'd64, 32'hFFFF_FF07, 4'h1);
        chk("R6 full out", {31'b0, full}, 32'd1);
        chk("R6 first out", {31'b0, first}, 32'd1);
        @(negedge clk); @(negedge clk);
        chk("R7 one start", start_cnt, s0 + 1);
        bus_read(8'd64, d); chk("R6 ctl readback", d, 32'd7);
        d = 0;
        for (int p = 0; p < 40 && d != 1; p++) bus_read(8'd68, d);
        chk("R8 status set", d, 32'd1);
        exp_tag = {mdl[11], mdl[10], mdl[9], mdl[8]} + {mdl[7], mdl[6], mdl[5], mdl[4]};
        for (int k = 0; k < 4; k++) begin
            bus_read(AW'(48 + 4*k), d); chk("R5 tag word", d, exp_tag[32*k +: 32]);
        end
        for (int k = 0; k < 4; k++) bus_write(AW'(48 + 4*k), 32'h0, 4'hF);
        for (int k = 0; k < 4; k++) begin
            bus_read(AW'(48 + 4*k), d); chk("R5 tag after write", d, exp_tag[32*k +: 32]);
        end

        // R7: load already high, rewrite gives no pulse; flags follow.
        bus_write(8'd64, 32'h2, 4'hF);
        repeat (3) @(negedge clk);
        chk("R7 no restart", start_cnt, s0 + 1);
        chk("R6 flags clear", {30'b0, full, first}, 32'd0);
        bus_write(8'd64, 32'h0, 4'h2);
        bus_read(8'd64, d); chk("R6 ctl needs be0", d, 32'd2);

        // R8: clear needs lane 0, stays set otherwise.
        bus_write(8'd68, 32'h0, 4'hE);
        bus_read(8'd68, d); chk("R8 status held", d, 32'd1);
        bus_write(8'd68, 32'h0, 4'h1);
        bus_read(8'd68, d); chk("R8 status cleared", d, 32'd0);

        // R7: drop load then raise it again: one more block.
        bus_write(8'd64, 32'h0, 4'h1);
        bus_write(8'd64, 32'h3, 4'h1);
        repeat (CORE_LAT + 4) @(negedge clk);
        chk("R7 second start", start_cnt, s0 + 2);
        bus_read(8'd68, d); chk("R8 second done", d, 32'd1);
        bus_write(8'd68, 32'h0, 4'h1);
        bus_read(8'd68, d); chk("R8 cleared again", d, 32'd0);

        // R9: ready and software clear in the same cycle.
        req = 1'b1; addr = 8'd68; we = 1'b1; wdata = 32'h0; be = 4'hF; man_ready = 1'b1;
        @(negedge clk);
        req = 1'b0; we = 1'b0; man_ready = 1'b0;
        bus_read(8'd68, d); chk("R9 hardware wins", d, 32'd1);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule